// File: doc/BRIEF.md
# Redundant Pairwise Address Sequencer

This block produces the address stream that drives a two-port march test on a memory of `n` locations. In pair mode it walks every ordered pair of distinct locations, so each unordered pair is visited twice: once with the lower address on the first port and once with it on the second. The full walk has `n(n-1)` elements. It can run the walk forward or in exactly the opposite order. In single mode it marches one address across the whole memory, either upward or downward.

The two outputs `addr_i` and `addr_j` are the two per-port address streams. The first port keeps one value for `n-1` steps before moving on. The second port lists every other address in ascending order. A consumer starts a run with `start`, takes one element per cycle in which `advance` is high, and watches `first`, `last` and `done` to frame the run. The memory access, the test data and the comparison of read data belong to other blocks.

Top module: `pair_addr_seq`

## Requirements
- R1: While reset is high, and after it until the first `start`, `valid`, `done`, `first` and `last` are all low.
- R2: A cycle with `start` high is followed by a cycle with `valid` and `first` high, carrying the first element for the chosen mode and direction. `first` is high only on that element.
- R3: Pair mode forward (`single_mode`=0, `dir_rev`=0) emits (i,j) for i from 0 to n-1, and within each i for j ascending from 0 to n-1. Pairs with j equal to i are skipped.
- R4: A pair-mode run has exactly n(n-1) elements, and `last` is high on the final element only.
- R5: Pair mode reverse (`dir_rev`=1) emits the R3 sequence in exactly the opposite order, starting at (n-1, n-2) and ending at (0, 1).
- R6: Single mode forward (`single_mode`=1, `dir_rev`=0) emits addresses 0 up to n-1 with `addr_j` equal to `addr_i`, and `last` is high on n-1.
- R7: Single mode reverse emits addresses n-1 down to 0 with `addr_j` equal to `addr_i`, and `last` is high on 0.
- R8: While `valid` is high and `advance` is low, the element does not change.
- R9: The cycle after the element flagged `last` is taken with `advance`, `valid` goes low and `done` goes high. `done` stays high until the next `start`, and `valid` and `done` are never both high.
- R10: A `start` during a run abandons it and restarts from the first element of the newly selected mode and direction. `n`, `dir_rev` and `single_mode` are sampled only when `start` is high.
- R11: The sequence is correct at the smallest legal size, n=2, and at the largest, n=2^AW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin or restart a run; samples `n_locs`, `dir_rev`, `single_mode` |
| dir_rev | input | 1 | 0 = forward order, 1 = reverse order |
| single_mode | input | 1 | 0 = ordered-pair walk, 1 = single-address march |
| advance | input | 1 | Take the current element and step to the next |
| n_locs | input | AW+1 | Number of memory locations, 2 to 2^AW |
| addr_i | output | AW | First-port address of the current element |
| addr_j | output | AW | Second-port address (equal to `addr_i` in single mode) |
| valid | output | 1 | An element is presented |
| first | output | 1 | Current element is the first of the run |
| last | output | 1 | Current element is the final one of the run |
| done | output | 1 | The run has completed |

## Verification
The bench targets the points where the pair walk crosses a diagonal or wraps to the next first-port address: i=0, where the skipped j is the very first one, and i=n-1, where the skipped j is the final one. A design that got the skip wrong would emit an (i,i) pair or lose a pair, and a wrong wrap would repeat or drop a whole row. The reverse walk is checked against the exact reversal of the forward list. An off-by-one at either end would show up as a missing (n-1,n-2) start or a missing (0,1) end. The bench runs n=2 and n=2^AW so that truncation of the count or the address widths shows up. It also stalls `advance` and restarts in the middle of a run, which catches a design that steps while stalled or that keeps the old position or direction after a new `start`.

// File: rtl/pairseq_pkg.sv
package pairseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef enum logic {
        WALK_FWD = 1'b0,
        WALK_REV = 1'b1
    } walk_dir_e;

    typedef enum logic {
        KIND_PAIR   = 1'b0,
        KIND_SINGLE = 1'b1
    } walk_kind_e;

    typedef struct packed {
        walk_dir_e  dir;
        walk_kind_e kind;
    } walk_cfg_t;

    function automatic walk_cfg_t make_cfg(input logic rev, input logic single);
        walk_cfg_t c;
        c.dir  = rev    ? WALK_REV    : WALK_FWD;
        c.kind = single ? KIND_SINGLE : KIND_PAIR;
        return c;
    endfunction

endpackage

// File: rtl/pair_walker.sv
module pair_walker
    import pairseq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] i_cur,
    input  logic [CW-1:0] j_cur,
    input  logic [CW-1:0] n_cnt,
    input  walk_dir_e     dir,
    output logic [CW-1:0] i_nxt,
    output logic [CW-1:0] j_nxt,
    output logic [CW-1:0] i_init,
    output logic [CW-1:0] j_init,
    output logic          at_end
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] j_up;
    logic [CW-1:0] j_up_skip;
    logic [CW-1:0] j_dn;
    logic [CW-1:0] n_m1;
    logic [CW-1:0] n_m2;

    always_comb begin
        n_m1      = n_cnt - ONE;
        n_m2      = n_cnt - TWO;
        j_up      = j_cur + ONE;
        j_up_skip = (j_up == i_cur) ? (j_up + ONE) : j_up;
        j_dn      = j_cur - ONE;
        i_nxt     = i_cur;
        j_nxt     = j_cur;
        if (dir == WALK_FWD) begin
            i_init = '0;
            j_init = ONE;
            at_end = (i_cur == n_m1) && (j_cur == n_m2);
            if (j_up_skip >= n_cnt) begin
                i_nxt = i_cur + ONE;
                j_nxt = '0;
            end else begin
                j_nxt = j_up_skip;
            end
        end else begin
            i_init = n_m1;
            j_init = n_m2;
            at_end = (i_cur == '0) && (j_cur == ONE);
            if (j_cur == '0) begin
                i_nxt = i_cur - ONE;
                j_nxt = n_m1;
            end else if (j_dn == i_cur) begin
                j_nxt = j_dn - ONE;
            end else begin
                j_nxt = j_dn;
            end
        end
    end

endmodule

// File: rtl/lin_walker.sv
module lin_walker
    import pairseq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] k_cur,
    input  logic [CW-1:0] n_cnt,
    input  walk_dir_e     dir,
    output logic [CW-1:0] k_nxt,
    output logic [CW-1:0] k_init,
    output logic          at_end
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        if (dir == WALK_FWD) begin
            k_init = '0;
            k_nxt  = k_cur + ONE;
            at_end = (k_cur == (n_cnt - ONE));
        end else begin
            k_init = n_cnt - ONE;
            k_nxt  = k_cur - ONE;
            at_end = (k_cur == '0);
        end
    end

endmodule

// File: rtl/pair_addr_seq.sv
module pair_addr_seq
    import pairseq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_rev,
    input  logic          single_mode,
    input  logic          advance,
    input  logic [AW:0]   n_locs,
    output logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_j,
    output logic          valid,
    output logic          first,
    output logic          last,
    output logic          done
);
    localparam int CW = AW + 1;

    seq_state_e    state_q;
    walk_cfg_t     cfg_q;
    walk_cfg_t     cfg_sel;
    logic [CW-1:0] n_q;
    logic [CW-1:0] n_sel;
    logic [CW-1:0] i_q;
    logic [CW-1:0] j_q;
    logic          first_q;

    logic [CW-1:0] p_i_nxt, p_j_nxt, p_i_init, p_j_init;
    logic          p_end;
    logic [CW-1:0] s_nxt, s_init;
    logic          s_end;
    logic          cur_end;

    // Configuration seen by the walkers: live inputs on a start cycle, latched otherwise.
    always_comb begin
        cfg_sel = start ? make_cfg(dir_rev, single_mode) : cfg_q;
        n_sel   = start ? n_locs : n_q;
    end

    pair_walker #(.CW(CW)) u_pair (
        .i_cur  (i_q),
        .j_cur  (j_q),
        .n_cnt  (n_sel),
        .dir    (cfg_sel.dir),
        .i_nxt  (p_i_nxt),
        .j_nxt  (p_j_nxt),
        .i_init (p_i_init),
        .j_init (p_j_init),
        .at_end (p_end)
    );

    lin_walker #(.CW(CW)) u_lin (
        .k_cur  (i_q),
        .n_cnt  (n_sel),
        .dir    (cfg_sel.dir),
        .k_nxt  (s_nxt),
        .k_init (s_init),
        .at_end (s_end)
    );

    assign cur_end = (cfg_q.kind == KIND_SINGLE) ? s_end : p_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= make_cfg(1'b0, 1'b0);
            n_q     <= '0;
            i_q     <= '0;
            j_q     <= '0;
            first_q <= 1'b0;
        end else if (start) begin
            state_q <= ST_RUN;
            cfg_q   <= cfg_sel;
            n_q     <= n_locs;
            first_q <= 1'b1;
            if (cfg_sel.kind == KIND_SINGLE) begin
                i_q <= s_init;
                j_q <= s_init;
            end else begin
                i_q <= p_i_init;
                j_q <= p_j_init;
            end
        end else if ((state_q == ST_RUN) && advance) begin
            first_q <= 1'b0;
            if (cur_end) begin
                state_q <= ST_DONE;
            end else if (cfg_q.kind == KIND_SINGLE) begin
                i_q <= s_nxt;
                j_q <= s_nxt;
            end else begin
                i_q <= p_i_nxt;
                j_q <= p_j_nxt;
            end
        end
    end

    assign valid  = (state_q == ST_RUN);
    assign done   = (state_q == ST_DONE);
    assign first  = valid && first_q;
    assign last   = valid && cur_end;
    assign addr_i = i_q[AW-1:0];
    assign addr_j = j_q[AW-1:0];

    // R2: a start is followed by the first element of the run
    p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (valid && first));

    // R3: in pair mode the two ports never address the same location
    p_pair_distinct_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && cfg_q.kind == KIND_PAIR) |-> (addr_i != addr_j));

    // R11: every presented address lies inside the sampled memory size
    p_in_range_r11: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((CW'(addr_i) < n_q) && (CW'(addr_j) < n_q)));

    // R8: a stalled element stays put
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && !advance && !start) |=> (valid && $stable(addr_i) && $stable(addr_j)));

    // R9: taking the last element ends the run
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && last && advance && !start) |=> (done && !valid));

    // R9: done persists until a new start
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: valid and done are exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({valid, done}));

endmodule

// File: tb/pair_addr_seq_test.sv
module pair_addr_seq_test;
    localparam int AW = 4;
    localparam int NMAX = 1 << AW;

    typedef struct {
        int i;
        int j;
        bit f;
        bit l;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          dir_rev = 1'b0;
    logic          single_mode = 1'b0;
    logic          advance = 1'b0;
    logic [AW:0]   n_locs = '0;
    logic [AW-1:0] addr_i, addr_j;
    logic          valid, first, last, done;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 1'b0;
    string cur_req = "R3";
    exp_t  q[$];

    bit            hold_armed = 1'b0;
    logic [AW-1:0] hold_i, hold_j;

    always #5 clk = ~clk;

    pair_addr_seq #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .dir_rev(dir_rev),
        .single_mode(single_mode), .advance(advance), .n_locs(n_locs),
        .addr_i(addr_i), .addr_j(addr_j), .valid(valid), .first(first),
        .last(last), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: pops an expected element each time one is taken
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_armed) begin
                check(valid && addr_i == hold_i && addr_j == hold_j, "R8",
                      "stalled element moved", int'(addr_i), int'(hold_i));
            end
            hold_armed = valid && !advance && !start;
            hold_i = addr_i;
            hold_j = addr_j;
            if (valid && advance && !start) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4", "extra element emitted", int'(addr_i), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(int'(addr_i) == e.i, cur_req, "addr_i", int'(addr_i), e.i);
                    check(int'(addr_j) == e.j, cur_req, "addr_j", int'(addr_j), e.j);
                    check(first == e.f, "R2", "first flag", int'(first), int'(e.f));
                    check(last == e.l, "R4", "last flag", int'(last), int'(e.l));
                end
            end
        end
    end

    // Driver: builds the expected list from the requirements and runs the sequencer.
    // stop_after = 0 runs to completion; otherwise it leaves after that many cycles.
    task automatic run(input int n, input bit rev, input bit single,
                       input bit stall, input int stop_after, input string req);
        exp_t lst[$];
        if (single) begin
            for (int k = 0; k < n; k++) lst.push_back('{k, k, 1'b0, 1'b0});
        end else begin
            for (int i = 0; i < n; i++)
                for (int j = 0; j < n; j++)
                    if (i != j) lst.push_back('{i, j, 1'b0, 1'b0});
        end
        if (rev) begin
            exp_t tmp[$];
            foreach (lst[k]) tmp.push_front(lst[k]);
            lst = tmp;
        end
        lst[0].f = 1'b1;
        lst[lst.size()-1].l = 1'b1;

        @(posedge clk); #1;
        q = lst;
        cur_req = req;
        n_locs = (AW+1)'(n);
        dir_rev = rev;
        single_mode = single;
        advance = 1'b0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n_locs = '0;
        dir_rev = ~rev;
        single_mode = ~single;
        advance = stall ? 1'b0 : 1'b1;
        @(negedge clk);
        check(valid && first, "R2", "valid&first after start",
              int'({valid, first}), 3);
        for (int cyc = 1; cyc < 4000; cyc++) begin
            if (done) break;
            if (stop_after != 0 && cyc > stop_after) break;
            @(posedge clk); #1;
            advance = stall ? (cyc % 3 != 0) : 1'b1;
            @(negedge clk);
        end
        if (stop_after == 0) begin
            check(q.size() == 0, "R4", "elements left unemitted", q.size(), 0);
            check(done && !valid, "R9", "done after last", int'({done, valid}), 2);
            @(posedge clk); #1;
            advance = 1'b1;
            @(negedge clk);
            check(done && !valid, "R9", "done held", int'({done, valid}), 2);
        end
        @(posedge clk); #1;
        advance = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!valid && !done && !first && !last, "R1", "outputs in reset",
              int'({valid, done, first, last}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!valid && !done && !first && !last, "R1", "outputs idle after reset",
              int'({valid, done, first, last}), 0);

        run(4, 1'b0, 1'b0, 1'b0, 0, "R3");
        run(5, 1'b0, 1'b0, 1'b1, 0, "R3");
        run(5, 1'b1, 1'b0, 1'b1, 0, "R5");
        run(2, 1'b0, 1'b0, 1'b0, 0, "R11");
        run(2, 1'b1, 1'b0, 1'b1, 0, "R11");
        run(NMAX, 1'b0, 1'b0, 1'b0, 0, "R11");
        run(NMAX, 1'b1, 1'b0, 1'b1, 0, "R11");
        run(6, 1'b0, 1'b1, 1'b1, 0, "R6");
        run(NMAX, 1'b0, 1'b1, 1'b0, 0, "R6");
        run(6, 1'b1, 1'b1, 1'b0, 0, "R7");
        run(2, 1'b1, 1'b1, 1'b1, 0, "R7");
        // R10: abandon a forward pair run partway, restart in reverse, then single
        run(5, 1'b0, 1'b0, 1'b0, 7, "R10");
        run(5, 1'b1, 1'b0, 1'b0, 9, "R10");
        run(7, 1'b1, 1'b1, 1'b1, 0, "R10");
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule